// File: doc/BRIEF.md
# CPU Clock Reconfiguration Sequencer

This block moves a CPU from one core frequency to another without ever running it from a clock that is being changed. A request in MHz arrives with a start strobe. The block limits the request to the highest frequency the PLL can produce. It picks the lowest entry of a fixed PLL setting table that meets or exceeds the request. From that frequency it derives the AXI, AHB and APB0 divider fields so that each bus stays under its frequency cap.

It then issues a fixed, timed series of writes on a simple register write port. First it parks the CPU on the 24 MHz crystal. After a settle gap it writes the new bus dividers and then the PLL configuration word. After a second settle gap it moves the CPU back onto the PLL. A status bit reports when the chosen frequency is not the one requested, and a one-cycle pulse marks the end of the series.

Two addresses are used. The clock configuration register holds the CPU source field and the bus dividers, and the block keeps a shadow copy of it. The PLL register takes the PLL word.

Top module: `cpu_clk_reseq`

## Requirements
- R1: A request above 1944 MHz is treated as exactly 1944 MHz, and a 1944 MHz request is then an exact match.
- R2: The PLL table has 15 entries: 384, 768, 960, 1008 through 1488 in steps of 48, and 1944. `sel_mhz_o` reports the first entry, in ascending order, that is at or above the limited request.
- R3: `mismatch_o` is 1 exactly when `sel_mhz_o` differs from the limited request.
- R4: The PLL word contains the following fields.
  - Fixed fields: bit 31 = 1, bits [29:26] = 8, bits [24:20] = 16, bits [14:13] = 2.
  - P exponent in [17:16], N in [12:8], K−1 in [5:4], and M−1 in [1:0]. All other bits are 0.
  - M = 1 and P = 0 throughout. The chosen frequency equals 24·N·K.
  - K is 1 for 384, 3 for 1944, and 2 for all other entries.
- R5: The configuration register field [2:0] carries axi−1, where axi = ceil(f/450).
- R6: The configuration register field [5:4] carries the AHB exponent, log2 of ceil(floor(f/axi)/250) rounded up to a power of two. Field [9:8] carries the fixed APB0 exponent 1.
- R7: The CPU source field is [17:16], with crystal = 01 and PLL = 10. The park write changes only that field. The divider write keeps the source field. The switch write changes only the source field.
- R8: The configuration register is at address 0 and the PLL register at address 1. With start captured at clock edge 0, writes occur only in the cycles after edges 0 (park), 9 (dividers), 10 (PLL word) and 19 (switch to PLL).
- R9: `busy_o` is high in the cycles after edges 0 through 19. `done_o` is high for one cycle only, after edge 20, with `busy_o` low.
- R10: A start while busy is ignored. It changes neither the write series, `sel_mhz_o` nor `mismatch_o`, and it does not begin a new series.
- R11: After reset, `busy_o`, `done_o`, `wr_en_o`, `mismatch_o` and `sel_mhz_o` are 0. The configuration shadow holds source = crystal with dividers 0, so the first park write carries 0x0001_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| req_mhz_i | input | 16 | Requested CPU frequency in MHz |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle end-of-series pulse |
| mismatch_o | output | 1 | Selected frequency differs from limited request |
| sel_mhz_o | output | 16 | Selected PLL frequency in MHz |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 4 | Register write address |
| wr_data_o | output | 32 | Register write data |

## Verification
The selected frequency and the mismatch bit appear in the cycle after the edge that takes the start. The four writes fall in the cycles after edges 0, 9, 10 and 19 counted from that edge, and the done pulse falls after edge 20. The bench drives the start on a falling edge. It then samples on every following falling edge for 22 cycles and checks the write port against a cycle-indexed expectation: an exact write in the four slots and a quiet bus in every other cycle. Expected fields come from the divider and PLL formulas evaluated in the bench. The bench also keeps its own model of the shadow register, so that source and divider preservation is checked across back-to-back series.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

  localparam int unsigned MHZ_W    = 16;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned NUM_ENT  = 15;
  localparam int unsigned XTAL_MHZ = 24;

  // configuration register layout
  localparam int unsigned AXI_LSB = 0;
  localparam int unsigned AXI_W   = 3;
  localparam int unsigned AHB_LSB = 4;
  localparam int unsigned AHB_W   = 2;
  localparam int unsigned APB_LSB = 8;
  localparam int unsigned APB_W   = 2;
  localparam int unsigned SRC_LSB = 16;
  localparam int unsigned SRC_W   = 2;

  localparam logic [SRC_W-1:0] SRC_OSC = 2'b01;
  localparam logic [SRC_W-1:0] SRC_PLL = 2'b10;

  localparam logic [DATA_W-1:0] DIV_MASK =
      (DATA_W'((1 << AXI_W) - 1) << AXI_LSB) |
      (DATA_W'((1 << AHB_W) - 1) << AHB_LSB) |
      (DATA_W'((1 << APB_W) - 1) << APB_LSB);
  localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'((1 << SRC_W) - 1) << SRC_LSB;
  localparam logic [DATA_W-1:0] CFG_RST  = DATA_W'(SRC_OSC) << SRC_LSB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PARK, ST_WAIT_A, ST_DIV, ST_PLL, ST_WAIT_B, ST_SWITCH
  } seq_st_e;

  localparam int ENT_M = 1;
  localparam int ENT_P = 0;

  function automatic int ent_n(int idx);
    if (idx == 0)           return 16;
    else if (idx == 1)      return 16;
    else if (idx == 2)      return 20;
    else if (idx == NUM_ENT - 1) return 27;
    else                    return 18 + idx;
  endfunction

  function automatic int ent_k(int idx);
    if (idx == 0)                return 1;
    else if (idx == NUM_ENT - 1) return 3;
    else                         return 2;
  endfunction

  function automatic int ent_mhz(int idx);
    return (XTAL_MHZ * ent_n(idx) * ent_k(idx)) / (ENT_M * (1 << ENT_P));
  endfunction

  function automatic logic [DATA_W-1:0] pll_word(int n, int k, int m, int pe);
    return 32'h8000_0000 | (32'd8 << 26) | (32'd16 << 20) | (32'd2 << 13) |
           (32'(pe) << 16) | (32'(n) << 8) | (32'(k - 1) << 4) | 32'(m - 1);
  endfunction

endpackage

// File: rtl/cpu_clk_pll_lut.sv
module cpu_clk_pll_lut
  import cpu_clk_pkg::*;
#(
  parameter int unsigned MAX_MHZ = 1944
) (
  input  logic [MHZ_W-1:0]  req_mhz_i,
  output logic [MHZ_W-1:0]  sel_mhz_o,
  output logic [DATA_W-1:0] pll_word_o,
  output logic              mismatch_o
);

  logic [MHZ_W-1:0] clamp_mhz;
  logic [NUM_ENT-1:0] ge;
  logic [NUM_ENT-1:0][MHZ_W-1:0]  ent_f;
  logic [NUM_ENT-1:0][DATA_W-1:0] ent_w;

  assign clamp_mhz = (req_mhz_i > MHZ_W'(MAX_MHZ)) ? MHZ_W'(MAX_MHZ) : req_mhz_i;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    localparam int F = ent_mhz(i);
    assign ent_f[i] = MHZ_W'(F);
    assign ent_w[i] = pll_word(ent_n(i), ent_k(i), ENT_M, ENT_P);
    assign ge[i]    = (ent_f[i] >= clamp_mhz);
  end

  // lowest entry that reaches the request; top entry is the fallback
  always_comb begin
    logic found;
    found      = 1'b0;
    sel_mhz_o  = ent_f[NUM_ENT-1];
    pll_word_o = ent_w[NUM_ENT-1];
    for (int i = 0; i < NUM_ENT; i++) begin
      if (!found && ge[i]) begin
        found      = 1'b1;
        sel_mhz_o  = ent_f[i];
        pll_word_o = ent_w[i];
      end
    end
  end

  assign mismatch_o = (sel_mhz_o != clamp_mhz);

endmodule

// File: rtl/cpu_clk_div_calc.sv
module cpu_clk_div_calc
  import cpu_clk_pkg::*;
#(
  parameter int unsigned AXI_CAP = 450,
  parameter int unsigned AHB_CAP = 250,
  parameter int unsigned MAX_AXI = 8,
  parameter int unsigned MAX_AHB = 4
) (
  input  logic [MHZ_W-1:0]  f_mhz_i,
  output logic [DATA_W-1:0] div_fields_o
);

  localparam int unsigned CNT_W = $clog2(MAX_AXI + MAX_AHB + 1);
  localparam int unsigned EXT_W = MHZ_W + CNT_W;

  logic [CNT_W-1:0] axi_n, ahb_n;
  logic [AHB_W-1:0] ahb_e;
  logic [EXT_W-1:0] f_ext;

  assign f_ext = EXT_W'(f_mhz_i);

  // ceil(f/AXI_CAP) by threshold count
  always_comb begin
    axi_n = CNT_W'(1);
    for (int k = 1; k < MAX_AXI; k++)
      if (f_ext > EXT_W'(AXI_CAP * k)) axi_n = axi_n + CNT_W'(1);
  end

  // ceil(floor(f/axi)/AHB_CAP): floor(f/axi) > C*j  <=>  f >= (C*j+1)*axi
  always_comb begin
    logic [EXT_W-1:0] thr;
    ahb_n = CNT_W'(1);
    for (int j = 1; j < MAX_AHB; j++) begin
      thr = EXT_W'(AHB_CAP * j + 1) * EXT_W'(axi_n);
      if (f_ext >= thr) ahb_n = ahb_n + CNT_W'(1);
    end
  end

  // round up to power of two, keep exponent
  always_comb begin
    ahb_e = '0;
    for (int e = 0; e < (1 << AHB_W) - 1; e++)
      if ((CNT_W'(1) << e) < ahb_n) ahb_e = AHB_W'(e + 1);
  end

  assign div_fields_o = (DATA_W'(AXI_W'(axi_n - CNT_W'(1))) << AXI_LSB) |
                        (DATA_W'(ahb_e) << AHB_LSB) |
                        (DATA_W'(APB_W'(1)) << APB_LSB);

endmodule

// File: rtl/cpu_clk_seq_fsm.sv
module cpu_clk_seq_fsm
  import cpu_clk_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8,
  parameter logic [ADDR_W-1:0] ADDR_CFG = 4'h0,
  parameter logic [ADDR_W-1:0] ADDR_PLL = 4'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [DATA_W-1:0] div_fields_i,
  input  logic [DATA_W-1:0] pll_word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] shadow_q;
  logic             settled;

  assign settled = (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign busy_o  = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE:   if (go_i) st_q <= ST_PARK;
        ST_PARK:   begin cnt_q <= '0; st_q <= ST_WAIT_A; end
        ST_WAIT_A: if (settled) st_q <= ST_DIV; else cnt_q <= cnt_q + CNT_W'(1);
        ST_DIV:    st_q <= ST_PLL;
        ST_PLL:    begin cnt_q <= '0; st_q <= ST_WAIT_B; end
        ST_WAIT_B: if (settled) st_q <= ST_SWITCH; else cnt_q <= cnt_q + CNT_W'(1);
        ST_SWITCH: begin done_o <= 1'b1; st_q <= ST_IDLE; end
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_addr_o = ADDR_CFG;
    wr_data_o = shadow_q;
    unique case (st_q)
      ST_PARK: begin
        wr_en_o   = 1'b1;
        wr_data_o = (shadow_q & ~SRC_MASK) | (DATA_W'(SRC_OSC) << SRC_LSB);
      end
      ST_DIV: begin
        wr_en_o   = 1'b1;
        wr_data_o = (shadow_q & ~DIV_MASK) | (div_fields_i & DIV_MASK);
      end
      ST_PLL: begin
        wr_en_o   = 1'b1;
        wr_addr_o = ADDR_PLL;
        wr_data_o = pll_word_i;
      end
      ST_SWITCH: begin
        wr_en_o   = 1'b1;
        wr_data_o = (shadow_q & ~SRC_MASK) | (DATA_W'(SRC_PLL) << SRC_LSB);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                shadow_q <= CFG_RST;
    else if (wr_en_o && wr_addr_o == ADDR_CFG)  shadow_q <= wr_data_o;
  end

endmodule

// File: rtl/cpu_clk_reseq.sv
module cpu_clk_reseq
  import cpu_clk_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8,
  parameter int unsigned MAX_MHZ    = 1944,
  parameter int unsigned AXI_CAP    = 450,
  parameter int unsigned AHB_CAP    = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       req_mhz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mismatch_o,
  output logic [15:0]       sel_mhz_o,
  output logic              wr_en_o,
  output logic [3:0]        wr_addr_o,
  output logic [31:0]       wr_data_o
);

  logic [MHZ_W-1:0]  lut_mhz;
  logic [DATA_W-1:0] lut_word, div_fields;
  logic              lut_mm, go;
  logic [DATA_W-1:0] word_q, div_q;

  cpu_clk_pll_lut #(.MAX_MHZ(MAX_MHZ)) u_lut (
    .req_mhz_i  (req_mhz_i),
    .sel_mhz_o  (lut_mhz),
    .pll_word_o (lut_word),
    .mismatch_o (lut_mm)
  );

  cpu_clk_div_calc #(.AXI_CAP(AXI_CAP), .AHB_CAP(AHB_CAP)) u_div (
    .f_mhz_i      (lut_mhz),
    .div_fields_o (div_fields)
  );

  assign go = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_mhz_o  <= '0;
      mismatch_o <= 1'b0;
      word_q     <= '0;
      div_q      <= '0;
    end else if (go) begin
      sel_mhz_o  <= lut_mhz;
      mismatch_o <= lut_mm;
      word_q     <= lut_word;
      div_q      <= div_fields;
    end
  end

  cpu_clk_seq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go),
    .div_fields_i (div_q),
    .pll_word_i   (word_q),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o)
  );

endmodule

// File: rtl/cpu_clk_reseq_chk.sv
module cpu_clk_reseq_chk
  import cpu_clk_pkg::*;
#(
  parameter int unsigned AXI_CAP = 450,
  parameter int unsigned AHB_CAP = 250
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        mismatch_o,
  input logic [15:0] sel_mhz_o,
  input logic        wr_en_o,
  input logic [3:0]  wr_addr_o,
  input logic [31:0] wr_data_o
);

  logic cfg_wr, pll_wr, sw_wr;
  logic [SRC_W-1:0] last_src_q;
  int unsigned axi_v, ahb_v;

  assign cfg_wr = wr_en_o && (wr_addr_o == 4'h0);
  assign pll_wr = wr_en_o && (wr_addr_o == 4'h1);
  assign sw_wr  = cfg_wr && (wr_data_o[SRC_LSB +: SRC_W] == SRC_PLL);
  assign axi_v  = 32'(wr_data_o[AXI_LSB +: AXI_W]) + 1;
  assign ahb_v  = 32'(1) << wr_data_o[AHB_LSB +: AHB_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_src_q <= SRC_OSC;
    else if (cfg_wr) last_src_q <= wr_data_o[SRC_LSB +: SRC_W];
  end

  AST_WR_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);  // R8
  AST_PLL_AFTER_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_wr |-> $past(cfg_wr));  // R8
  AST_PLL_ON_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_wr |-> (last_src_q == SRC_OSC));  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R9
  AST_DONE_AFTER_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(sw_wr) && !busy_o));  // R9
  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(sel_mhz_o) && $stable(mismatch_o)));  // R10
  AST_AXI_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr |-> (32'(sel_mhz_o) <= AXI_CAP * axi_v));  // R5
  AST_AHB_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr |-> (32'(sel_mhz_o) / axi_v <= AHB_CAP * ahb_v));  // R6

endmodule

bind cpu_clk_reseq cpu_clk_reseq_chk #(.AXI_CAP(AXI_CAP), .AHB_CAP(AHB_CAP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mismatch_o (mismatch_o),
  .sel_mhz_o  (sel_mhz_o),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o)
);

// File: tb/tb_cpu_clk_reseq.sv
module tb_cpu_clk_reseq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] req_mhz_i = '0;
  logic        busy_o, done_o, mismatch_o, wr_en_o;
  logic [15:0] sel_mhz_o;
  logic [3:0]  wr_addr_o;
  logic [31:0] wr_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow_m = 32'h0001_0000;

  // {request, expected selection, expected mismatch}
  localparam logic [32:0] VECS [NVEC] = '{
    {16'd0,     16'd384,  1'b1},
    {16'd384,   16'd384,  1'b0},
    {16'd385,   16'd768,  1'b1},
    {16'd960,   16'd960,  1'b0},
    {16'd1000,  16'd1008, 1'b1},
    {16'd1056,  16'd1056, 1'b0},
    {16'd1344,  16'd1344, 1'b0},
    {16'd1345,  16'd1392, 1'b1},
    {16'd1488,  16'd1488, 1'b0},
    {16'd1489,  16'd1944, 1'b1},
    {16'd1944,  16'd1944, 1'b0},
    {16'd2000,  16'd1944, 1'b0},
    {16'd5000,  16'd1944, 1'b0},
    {16'd65535, 16'd1944, 1'b0}
  };

  cpu_clk_reseq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .req_mhz_i(req_mhz_i),
    .busy_o(busy_o), .done_o(done_o), .mismatch_o(mismatch_o), .sel_mhz_o(sel_mhz_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [15:0] req, input logic [15:0] exp_sel, input logic exp_mm,
                         input int poke_c, input logic [15:0] poke_req);
    int axi, q, ahb, ahbe, n, k;
    logic [31:0] word, d_park, d_div, d_sw;
    logic [36:0] exp_w, act_w;
    axi  = (exp_sel + 449) / 450;
    q    = exp_sel / axi;
    ahb  = (q + 249) / 250;
    ahbe = (ahb <= 1) ? 0 : (ahb <= 2) ? 1 : 2;
    k    = (exp_sel == 384) ? 1 : (exp_sel == 1944) ? 3 : 2;
    n    = exp_sel / (24 * k);
    chk(24 * n * k == exp_sel, "R4 freq equals 24*N*K", 24 * n * k, exp_sel);
    word   = 32'h8000_0000 | (32'd8 << 26) | (32'd16 << 20) | (32'd2 << 13) |
             (32'(n) << 8) | (32'(k - 1) << 4);
    d_park = (shadow_m & ~32'h0003_0000) | 32'h0001_0000;
    d_div  = (d_park & ~32'h0000_0337) | 32'(axi - 1) | (32'(ahbe) << 4) | 32'h0000_0100;
    d_sw   = (d_div & ~32'h0003_0000) | 32'h0002_0000;

    @(negedge clk_i);
    start_i = 1'b1; req_mhz_i = req;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c <= 21; c++) begin
      act_w = {wr_en_o, wr_addr_o, wr_data_o};
      if (c == 0)       exp_w = {1'b1, 4'h0, d_park};
      else if (c == 9)  exp_w = {1'b1, 4'h0, d_div};
      else if (c == 10) exp_w = {1'b1, 4'h1, word};
      else if (c == 19) exp_w = {1'b1, 4'h0, d_sw};
      else              exp_w = '0;
      if (exp_w[36]) chk(act_w == exp_w, $sformatf("R8 R7 R5 R6 R4 write slot c=%0d req=%0d", c, req), act_w, exp_w);
      else           chk(!wr_en_o, $sformatf("R8 R10 quiet c=%0d req=%0d", c, req), act_w, exp_w);
      chk(busy_o == (c <= 19), $sformatf("R9 busy c=%0d", c), busy_o, c <= 19);
      chk(done_o == (c == 20), $sformatf("R9 done c=%0d", c), done_o, c == 20);
      chk(sel_mhz_o == exp_sel, $sformatf("R2 R1 R10 sel req=%0d c=%0d", req, c), sel_mhz_o, exp_sel);
      chk(mismatch_o == exp_mm, $sformatf("R3 R10 mismatch req=%0d c=%0d", req, c), mismatch_o, exp_mm);
      if (c == poke_c) begin start_i = 1'b1; req_mhz_i = poke_req; end
      else start_i = 1'b0;
      @(negedge clk_i);
    end
    shadow_m = d_sw;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk({busy_o, done_o, wr_en_o, mismatch_o} == 4'b0, "R11 reset flags",
        {busy_o, done_o, wr_en_o, mismatch_o}, 0);
    chk(sel_mhz_o == 16'd0, "R11 reset selection", sel_mhz_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // first series: park write must carry the reset shadow (R11)
    for (int i = 0; i < NVEC; i++) begin
      int pc;
      logic [15:0] pr;
      pc = -1; pr = '0;
      if (i == 3) begin pc = 5;  pr = 16'd1944; end  // R10 mid-series start
      if (i == 5) begin pc = 19; pr = 16'd384;  end  // R10 start in switch cycle
      if (i == 7) begin pc = 0;  pr = 16'd768;  end  // R10 start in park cycle
      run_seq(VECS[i][32:17], VECS[i][16:1], VECS[i][0], pc, pr);
    end
    // R11 again after a fresh reset: shadow back to crystal, dividers 0
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk({busy_o, wr_en_o, sel_mhz_o} == '0, "R11 re-reset", {busy_o, wr_en_o, sel_mhz_o}, 0);
    rst_ni = 1'b1;
    shadow_m = 32'h0001_0000;
    run_seq(16'd1100, 16'd1104, 1'b1, -1, '0);
    run_seq(16'd1104, 16'd1104, 1'b0, -1, '0);  // R7 dividers/source preserved back to back
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule